// File: doc/BRIEF.md
# Tree Sum Reduction Engine

This block folds a set of signed partial sums, one per processing element, into a single total. It works in lock-step rounds. At every round the active elements split at a boundary: each element above the boundary hands its value to a partner that sits exactly one boundary-width below it, and that partner adds the value to its own. The active range then shrinks to the boundary, and the rounds continue until a single value is left in element 0.

The boundary is found by halving the active count and rounding up, and a separate sender limit is kept. Because of this, counts that are not a power of two (seven, a hundred) need no padding: the odd element left in the middle just waits for a later round. Each round takes one clock cycle, and all additions within it happen in parallel. A one-cycle start pulse captures all inputs at once. A done flag marks the point where the total on the output is final. The output is wide enough that no input pattern can make it overflow.

Top module: `treesum_engine`

## Requirements
- R1: After reset, done is low and total reads zero.
- R2: A start pulse accepted while the engine is idle or finished captures all N inputs. Each input is a DW-bit two's complement value, and input k occupies bits k*DW up to k*DW+DW-1. On the next cycle, total shows input 0 sign-extended to the output width.
- R3: Each busy cycle is one round. With the active count c, the stride is ceil(c/2). Every element p below floor(c/2) adds the value of element p+stride. The active count then becomes the stride.
- R4: done rises on the clock edge of the round that brings the active count to 1. That makes 7 rounds after the load edge for N=100, 3 for N=7 and 1 for N=2. For N=1, done rises on the load edge itself.
- R5: While done is high, total equals the exact signed sum of the captured inputs. This holds even when every input is the most positive or the most negative DW-bit value. The output width is DW+ceil(log2 N).
- R6: A start pulse that arrives while rounds are in progress is ignored. The running reduction and its result are unaffected.
- R7: While done is high and no start arrives, done and total hold their values. A start while done is high reloads all inputs and begins a new reduction.
- R8: Counts that are not a power of two reduce correctly without padding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load-and-run request, sampled at the rising edge |
| partIn | input | N*DW | Packed partial sums, element k in bits [k*DW +: DW] |
| done | output | 1 | High once the reduction has finished |
| total | output | DW+ceil(log2 N) | Value of element 0, the full sum once done is high |

## Verification
Two situations are the hardest to create from the ports. The first is a start that lands partway through the rounds, which must be ignored. The second is an element that sits idle during one round and joins a later one, which happens only for odd active counts. Four copies are driven side by side with sizes 100, 7, 2 and 1, so the same start timing hits each of them in a different phase. Back-to-back runs use random gaps after the start, which places fresh start pulses both inside the rounds and after done. Runs where every input is the most positive or the most negative value test the output width.

// File: rtl/treesum_pkg.sv
package treesum_pkg;
  // Width of the round counters exchanged between control and datapath.
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  // Strobes from the sequencer to the element array.
  typedef struct packed {
    logic load;      // capture all inputs this edge
    logic step;      // perform one reduction round this edge
    cnt_t stride;    // distance from receiver to sender this round
    cnt_t addCount;  // receivers are elements 0 .. addCount-1
  } strobe_t;
endpackage

// File: rtl/treesum_ctrl.sv
module treesum_ctrl
  import treesum_pkg::*;
#(
  parameter int N = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobes,
  output logic    done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  localparam cnt_t COUNT_INIT = cnt_t'(N);
  localparam logic SINGLE = (N == 1);

  state_t state;
  cnt_t   activeCount;
  cnt_t   nextStride;
  logic   accept;

  assign nextStride = (activeCount + cnt_t'(1)) >> 1;
  assign accept     = start && (state != S_RUN);

  always_comb begin
    strobes          = '0;
    strobes.load     = accept;
    strobes.step     = (state == S_RUN);
    strobes.stride   = nextStride;
    strobes.addCount = activeCount >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      activeCount <= '0;
    end else if (accept) begin
      activeCount <= COUNT_INIT;
      state       <= SINGLE ? S_FIN : S_RUN;
    end else if (state == S_RUN) begin
      activeCount <= nextStride;
      if (nextStride == cnt_t'(1)) state <= S_FIN;
    end
  end

  assign done = (state == S_FIN);

  // Each round must shrink the active range.
  assert_round_shrinks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |=> (activeCount < $past(activeCount)));

  // Done is only reached with one value left.
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (activeCount == cnt_t'(1)));

  // A start during the rounds does not restart the count.
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && start) |=> (activeCount < COUNT_INIT));

  // Finished state holds without a new start.
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(activeCount)));
endmodule

// File: rtl/treesum_datapath.sv
module treesum_datapath
  import treesum_pkg::*;
#(
  parameter int N  = 100,
  parameter int DW = 16,
  parameter int SW = DW + $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [N*DW-1:0]      partIn,
  output logic signed [SW-1:0] total
);
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam int WIDE_W = $clog2(2 * N) + 2;

  logic signed [SW-1:0] accView [N];

  for (genvar p = 0; p < N; p++) begin : g_elem
    logic signed [SW-1:0] elemQ;
    logic [WIDE_W-1:0]    partnerWide;
    logic [IDX_W-1:0]     partnerIdx;
    logic                 addEn;

    assign partnerWide = WIDE_W'(p) + WIDE_W'(strobes.stride);
    assign partnerIdx  = (partnerWide < WIDE_W'(N)) ? partnerWide[IDX_W-1:0]
                                                     : IDX_W'(N - 1);
    assign addEn       = strobes.step && (cnt_t'(p) < strobes.addCount);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             elemQ <= '0;
      else if (strobes.load) elemQ <= SW'($signed(partIn[p*DW +: DW]));
      else if (addEn)        elemQ <= elemQ + accView[partnerIdx];
    end

    assign accView[p] = elemQ;
  end

  assign total = accView[0];

  // Load captures element 0 sign-extended.
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (total == SW'($signed($past(partIn[DW-1:0])))));

  // Senders and receivers never overlap inside a round.
  assert_disjoint_roles_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> (strobes.stride >= strobes.addCount));

  // Without load or round the result is frozen.
  assert_quiet_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(total));
endmodule

// File: rtl/treesum_engine.sv
module treesum_engine
  import treesum_pkg::*;
#(
  parameter int  N  = 100,
  parameter int  DW = 16,
  localparam int SW = DW + $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [N*DW-1:0]      partIn,
  output logic                 done,
  output logic signed [SW-1:0] total
);
  strobe_t strobes;

  treesum_ctrl #(.N(N)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  treesum_datapath #(.N(N), .DW(DW), .SW(SW)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .partIn  (partIn),
    .total   (total)
  );
endmodule

// File: tb/test_treesum_engine.sv
module test_treesum_engine;
  localparam int DW    = 12;
  localparam int LANES = 4;
  localparam int MAXN  = 100;
  localparam int SZ [LANES] = '{100, 7, 2, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  longint vals [LANES][MAXN];
  logic [100*DW-1:0] in0;
  logic [7*DW-1:0]   in1;
  logic [2*DW-1:0]   in2;
  logic [1*DW-1:0]   in3;
  logic done0, done1, done2, done3;
  logic signed [DW+7-1:0] tot0;
  logic signed [DW+3-1:0] tot1;
  logic signed [DW+1-1:0] tot2;
  logic signed [DW-1:0]   tot3;

  always_comb begin
    for (int p = 0; p < 100; p++) in0[p*DW +: DW] = vals[0][p][DW-1:0];
    for (int p = 0; p < 7; p++)   in1[p*DW +: DW] = vals[1][p][DW-1:0];
    for (int p = 0; p < 2; p++)   in2[p*DW +: DW] = vals[2][p][DW-1:0];
    in3 = vals[3][0][DW-1:0];
  end

  // Lanes 0 and 1 (sizes 100 and 7) cover R8.
  treesum_engine #(.N(100), .DW(DW)) i_treesum_engine (
    .clk(clk), .rstN(rstN), .start(start), .partIn(in0), .done(done0), .total(tot0));
  treesum_engine #(.N(7), .DW(DW)) i_treesum_engine_n7 (
    .clk(clk), .rstN(rstN), .start(start), .partIn(in1), .done(done1), .total(tot1));
  treesum_engine #(.N(2), .DW(DW)) i_treesum_engine_n2 (
    .clk(clk), .rstN(rstN), .start(start), .partIn(in2), .done(done2), .total(tot2));
  treesum_engine #(.N(1), .DW(DW)) i_treesum_engine_n1 (
    .clk(clk), .rstN(rstN), .start(start), .partIn(in3), .done(done3), .total(tot3));

  // Behavioural model: 0 idle, 1 running, 2 finished.
  longint model [LANES][MAXN];
  int     cnt   [LANES];
  int     st    [LANES];
  string  tag   [LANES];
  int compared = 0;
  int mismatched = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < LANES; l++) begin
        st[l] = 0; cnt[l] = 0; tag[l] = "R1";
        for (int p = 0; p < MAXN; p++) model[l][p] = 0;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (start && st[l] != 1) begin
          tag[l] = (st[l] == 2) ? "R7" : "R2";
          for (int p = 0; p < SZ[l]; p++) model[l][p] = vals[l][p];
          cnt[l] = SZ[l];
          st[l] = (SZ[l] == 1) ? 2 : 1;
        end else if (st[l] == 1) begin
          int h;
          h = (cnt[l] + 1) / 2;
          for (int p = 0; p < cnt[l] / 2; p++) model[l][p] += model[l][p + h];
          cnt[l] = h;
          if (h == 1) st[l] = 2;
          tag[l] = start ? "R6" : ((h == 1) ? "R5" : "R3");
        end else if (st[l] == 2) begin
          tag[l] = "R7";
        end
      end
    end
  end

  always @(negedge clk) begin
    longint act [LANES];
    logic   dn  [LANES];
    act[0] = tot0; act[1] = tot1; act[2] = tot2; act[3] = tot3;
    dn[0] = done0; dn[1] = done1; dn[2] = done2; dn[3] = done3;
    for (int l = 0; l < LANES; l++) begin
      compared += 2;
      if (dn[l] !== (st[l] == 2)) begin
        mismatched++;
        $display("FAIL R4 (%s) N=%0d done: actual %0b expected %0b at %0t",
                 tag[l], SZ[l], dn[l], (st[l] == 2), $time);
      end
      if (act[l] != model[l][0]) begin
        mismatched++;
        $display("FAIL %s N=%0d total: actual %0d expected %0d at %0t",
                 tag[l], SZ[l], act[l], model[l][0], $time);
      end
    end
  end

  task automatic setData(input int kind);
    for (int l = 0; l < LANES; l++)
      for (int p = 0; p < MAXN; p++)
        case (kind)
          1:       vals[l][p] = (1 << (DW - 1)) - 1;   // R5 max positive
          2:       vals[l][p] = -(1 << (DW - 1));      // R5 most negative
          default: vals[l][p] = longint'($urandom_range(4095)) - 2048;
        endcase
  endtask

  task automatic pulse(input int gap);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    setData(0);
    repeat (3) @(negedge clk);  // R1 reset state checked every cycle
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin setData(0); pulse(10); end  // R2 R3 R4
    setData(1); pulse(10);      // R5 upper extreme
    setData(2); pulse(10);      // R5 lower extreme
    setData(0); pulse(2);       // R6: start mid-run with new data
    setData(0); pulse(10);
    setData(0);                 // R7: held start reloads after done
    @(negedge clk); start = 1'b1;
    repeat (12) @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      setData(k % 5 == 4 ? 1 + (k % 2) : 0);
      pulse($urandom_range(10));
    end
    repeat (10) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule